// File: doc/BRIEF.md
# Saturating Float to Integer Converter

This block turns an IEEE 754 binary32 or binary64 value into a signed two's-complement integer of 32 or 64 bits. Any fractional part is dropped, which rounds toward zero. The conversion never raises an exception: NaN gives zero, and infinities or magnitudes that are too large clamp to the extreme integer of the chosen width on the side of the input's sign.

The caller places the operand on a 64-bit bus. A binary32 operand sits in the low 32 bits. Two selects choose the source format and the result width. One clock after `in_valid` is asserted, a registered result appears together with `out_valid`. A 32-bit result occupies bits 31:0, and bits 63:32 carry its sign.

Top module: `f2i_sat_conv`

## Requirements
- R1: Finite in-range inputs round toward zero for both signs: 2.75 gives 2, -2.75 gives -2, and -1.5 gives -1.
- R2: Any NaN input (all exponent bits set, fraction nonzero) gives 0 for every format and width combination.
- R3: Both zeros, denormals and every magnitude below 1.0 give 0.
- R4: Positive infinity and positive values of 2^31 (32-bit result) or 2^63 (64-bit result) and above give 0x7fffffff or 0x7fffffffffffffff.
- R5: Negative infinity and negative values below -2^31 or -2^63 give -2^31 (0xffffffff80000000 on the bus) or -2^63.
- R6: An input exactly equal to -2^31 (32-bit result) or -2^63 (64-bit result) converts exactly to that value.
- R7: With `src_dbl`=0 the operand is bits 31:0. Bits 63:32 have no effect on the result.
- R8: With `dst_long`=0, bits 63:32 of `result` equal bit 31. With `dst_long`=1 the full 64-bit value is given, and binary64 magnitudes above 2^52 are exact.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and `result` then holds that input's conversion.
- R10: While `rst_n` is low at a clock edge, `out_valid` and `result` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| src_dbl | input | 1 | 1: binary64 operand, 0: binary32 in bits 31:0 |
| dst_long | input | 1 | 1: 64-bit result, 0: 32-bit result sign-extended |
| src_bits | input | 64 | Floating-point operand |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Converted integer |

## Verification
Saturation and exact conversion meet at the most negative integer. An input of exactly -2^31 or -2^63 takes the exact path, while a value one unit further out takes the overflow path, and both must produce the same pattern. The bench provokes both sides of that boundary in both source formats. It compares each result against the hand-derived extreme value. It also pairs NaN, which has the same all-ones exponent as infinity, with the infinities, which checks that the fraction test is what picks zero over saturation.

// File: rtl/f2i_pkg.sv
// Shared constants and the decoded-operand record used by the converter.
package f2i_pkg;
    localparam int DW_EXP  = 11;               // binary64 exponent width
    localparam int DW_FRAC = 52;               // binary64 fraction width
    localparam int SW_EXP  = 8;                // binary32 exponent width
    localparam int SW_FRAC = 23;               // binary32 fraction width
    localparam int DBIAS   = 1023;
    localparam int SBIAS   = 127;
    localparam int MANT_W  = DW_FRAC + 1;      // mantissa with hidden bit
    localparam int EXP_W   = DW_EXP + 2;       // signed unbiased exponent

    typedef struct packed {
        logic                    sign;
        logic                    nan;
        logic                    inf;
        logic                    tiny;   // zero, denormal or |x| < 1
        logic                    frac_zero;
        logic signed [EXP_W-1:0] exp_unb;
        logic [MANT_W-1:0]       mant;   // hidden bit at MSB
    } f2i_cls_t;
endpackage

// File: rtl/f2i_unpack.sv
// Splits a binary32 or binary64 operand into sign, unbiased exponent and a
// left-aligned 53-bit mantissa, and classifies it.
// Assumes a binary32 operand sits in bits 31:0; upper bits are ignored.
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic        src_dbl,
    input  logic [63:0] src_bits,
    output f2i_cls_t    cls
);
    logic [DW_EXP-1:0]  exp_f;
    logic [DW_FRAC-1:0] frac_f;
    logic               exp_ones;
    logic               exp_zero;

    // Pick fields of the selected format and widen them to a common shape.
    always_comb begin
        if (src_dbl) begin
            exp_f    = src_bits[62:52];
            frac_f   = src_bits[51:0];
            exp_ones = &src_bits[62:52];
            exp_zero = ~|src_bits[62:52];
            cls.sign = src_bits[63];
            cls.exp_unb = EXP_W'($signed({2'b00, exp_f})) - EXP_W'(DBIAS);
        end else begin
            exp_f    = {3'b000, src_bits[30:23]};
            frac_f   = {src_bits[22:0], 29'b0};
            exp_ones = &src_bits[30:23];
            exp_zero = ~|src_bits[30:23];
            cls.sign = src_bits[31];
            cls.exp_unb = EXP_W'($signed({2'b00, exp_f})) - EXP_W'(SBIAS);
        end
    end

    // Classify the operand.
    always_comb begin
        cls.frac_zero = ~|frac_f;
        cls.nan       = exp_ones & ~cls.frac_zero;
        cls.inf       = exp_ones & cls.frac_zero;
        cls.tiny      = exp_zero | (cls.exp_unb < 0);
        cls.mant      = {~exp_zero, frac_f};
    end
endmodule

// File: rtl/f2i_shift_sat.sv
// Produces the integer from a decoded operand: aligns the mantissa by the
// exponent, applies the sign, and clamps NaN, infinity and overflow.
// Assumes the decoded record from f2i_unpack.
module f2i_shift_sat
    import f2i_pkg::*;
#(
    parameter int OUT_W = 64,
    parameter int NARROW_W = 32
) (
    input  f2i_cls_t          cls,
    input  logic              dst_long,
    output logic [OUT_W-1:0]  value
);
    localparam int SH_W = $clog2(OUT_W) + 1;
    localparam logic [OUT_W-1:0] MAX_L = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MIN_L = {1'b1, {(OUT_W-1){1'b0}}};
    localparam logic [OUT_W-1:0] MAX_N = {{(OUT_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MIN_N = {{(OUT_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};

    logic signed [EXP_W-1:0] lim;
    logic [OUT_W-1:0]        wide_m;
    logic [OUT_W-1:0]        mag;
    logic [OUT_W-1:0]        signed_v;
    logic [SH_W-1:0]         sh_amt;
    logic                    over;
    logic                    exact_min;

    // Align the mantissa: right shift below 2^52, left shift above.
    always_comb begin
        wide_m = OUT_W'(cls.mant);
        sh_amt = '0;
        mag    = '0;
        if (!cls.tiny && cls.exp_unb <= EXP_W'(MANT_W - 1)) begin
            sh_amt = SH_W'(EXP_W'(MANT_W - 1) - cls.exp_unb);
            mag    = wide_m >> sh_amt;
        end else if (!cls.tiny && cls.exp_unb < EXP_W'(OUT_W)) begin
            sh_amt = SH_W'(cls.exp_unb - EXP_W'(MANT_W - 1));
            mag    = wide_m << sh_amt;
        end
    end

    // Decide range, then select saturated, zero or signed magnitude.
    always_comb begin
        lim       = dst_long ? EXP_W'(OUT_W - 1) : EXP_W'(NARROW_W - 1);
        exact_min = cls.sign & cls.frac_zero & (cls.exp_unb == lim);
        over      = cls.inf | (!cls.tiny && cls.exp_unb >= lim && !exact_min);
        signed_v  = cls.sign ? (~mag + 1'b1) : mag;
        if (cls.nan) begin
            value = '0;
        end else if (over || exact_min) begin
            if (dst_long) value = cls.sign ? MIN_L : MAX_L;
            else          value = cls.sign ? MIN_N : MAX_N;
        end else if (cls.tiny) begin
            value = '0;
        end else if (dst_long) begin
            value = signed_v;
        end else begin
            value = {{(OUT_W-NARROW_W){signed_v[NARROW_W-1]}}, signed_v[NARROW_W-1:0]};
        end
    end
endmodule

// File: rtl/f2i_sat_conv.sv
// Top of the converter: one register stage after the combinational unpack
// and align/saturate logic. Assumes a synchronous active-low reset.
module f2i_sat_conv
    import f2i_pkg::*;
#(
    parameter int OUT_W = 64,
    parameter int NARROW_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             src_dbl,
    input  logic             dst_long,
    input  logic [63:0]      src_bits,
    output logic             out_valid,
    output logic [OUT_W-1:0] result
);
    f2i_cls_t         cls;
    logic [OUT_W-1:0] conv;

    f2i_unpack u_unpack (
        .src_dbl  (src_dbl),
        .src_bits (src_bits),
        .cls      (cls)
    );

    f2i_shift_sat #(.OUT_W(OUT_W), .NARROW_W(NARROW_W)) u_shift (
        .cls      (cls),
        .dst_long (dst_long),
        .value    (conv)
    );

    // Output stage: capture a converted operand, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= conv;
        end
    end

    p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_nan_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls.nan) |=> (result == '0));
    p_pos_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls.inf && !cls.sign && dst_long) |=>
        (result == {1'b0, {(OUT_W-1){1'b1}}}));
    p_neg_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls.inf && cls.sign && !dst_long) |=>
        (result == {{(OUT_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}}));
    p_sext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dst_long) |=>
        (result[OUT_W-1:NARROW_W] == {(OUT_W-NARROW_W){result[NARROW_W-1]}}));
    p_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cls.nan && cls.sign) |=> (result[OUT_W-1] || result == '0));
endmodule

// File: tb/tb_f2i_sat_conv.sv
module tb_f2i_sat_conv;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        src_dbl = 1'b0;
    logic        dst_long = 1'b0;
    logic [63:0] src_bits = '0;
    logic        out_valid;
    logic [63:0] result;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    f2i_sat_conv dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_dbl(src_dbl),
        .dst_long(dst_long), .src_bits(src_bits), .out_valid(out_valid),
        .result(result)
    );

    // {req, src_dbl, dst_long, src, expected}
    localparam logic [137:0] VEC [NV] = '{
        {8'd1,  1'b0, 1'b0, 64'h0000_0000_4030_0000, 64'h0000_0000_0000_0002}, // R1 2.75
        {8'd1,  1'b0, 1'b1, 64'h0000_0000_C030_0000, 64'hFFFF_FFFF_FFFF_FFFE}, // R1 -2.75
        {8'd1,  1'b1, 1'b0, 64'h4006_0000_0000_0000, 64'h0000_0000_0000_0002}, // R1
        {8'd1,  1'b1, 1'b1, 64'hBFF8_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF}, // R1 -1.5
        {8'd2,  1'b0, 1'b0, 64'h0000_0000_7FC0_0000, 64'h0},                   // R2
        {8'd2,  1'b1, 1'b1, 64'h7FF8_0000_0000_0000, 64'h0},                   // R2
        {8'd2,  1'b1, 1'b0, 64'hFFF0_0000_0000_0001, 64'h0},                   // R2 neg NaN
        {8'd3,  1'b0, 1'b0, 64'h0000_0000_8000_0000, 64'h0},                   // R3 -0
        {8'd3,  1'b0, 1'b1, 64'h0000_0000_0000_0001, 64'h0},                   // R3 denormal
        {8'd3,  1'b0, 1'b0, 64'h0000_0000_BF00_0000, 64'h0},                   // R3 -0.5
        {8'd3,  1'b1, 1'b1, 64'h3FEF_FFFF_FFFF_FFFF, 64'h0},                   // R3 <1
        {8'd4,  1'b0, 1'b0, 64'h0000_0000_7F80_0000, 64'h0000_0000_7FFF_FFFF}, // R4 +inf
        {8'd4,  1'b0, 1'b0, 64'h0000_0000_4F00_0000, 64'h0000_0000_7FFF_FFFF}, // R4 2^31
        {8'd4,  1'b1, 1'b1, 64'h43E0_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF}, // R4 2^63
        {8'd4,  1'b1, 1'b0, 64'h41E0_0000_0000_0000, 64'h0000_0000_7FFF_FFFF}, // R4
        {8'd5,  1'b0, 1'b1, 64'h0000_0000_FF80_0000, 64'h8000_0000_0000_0000}, // R5 -inf
        {8'd5,  1'b1, 1'b0, 64'hC1E0_0000_0020_0000, 64'hFFFF_FFFF_8000_0000}, // R5 -(2^31+1)
        {8'd5,  1'b1, 1'b1, 64'hFFF0_0000_0000_0000, 64'h8000_0000_0000_0000}, // R5
        {8'd6,  1'b0, 1'b0, 64'h0000_0000_CF00_0000, 64'hFFFF_FFFF_8000_0000}, // R6
        {8'd6,  1'b1, 1'b0, 64'hC1E0_0000_0000_0000, 64'hFFFF_FFFF_8000_0000}, // R6
        {8'd6,  1'b1, 1'b1, 64'hC3E0_0000_0000_0000, 64'h8000_0000_0000_0000}, // R6
        {8'd6,  1'b0, 1'b1, 64'h0000_0000_CF00_0000, 64'hFFFF_FFFF_8000_0000}, // R6 in range
        {8'd7,  1'b0, 1'b0, 64'hDEAD_BEEF_4030_0000, 64'h0000_0000_0000_0002}, // R7
        {8'd7,  1'b0, 1'b1, 64'hFFFF_FFFF_7FC0_0000, 64'h0},                   // R7
        {8'd8,  1'b0, 1'b1, 64'h0000_0000_4F00_0000, 64'h0000_0000_8000_0000}, // R8
        {8'd8,  1'b1, 1'b1, 64'h4340_0000_0000_0001, 64'h0020_0000_0000_0002}, // R8 >2^52
        {8'd8,  1'b1, 1'b1, 64'hC340_0000_0000_0001, 64'hFFDF_FFFF_FFFF_FFFE}, // R8
        {8'd8,  1'b1, 1'b0, 64'hC006_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFE}  // R8
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic convert(input logic d, input logic l, input logic [63:0] s);
        @(negedge clk);
        in_valid = 1'b1; src_dbl = d; dst_long = l; src_bits = s;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R10: reset clears the output stage
        repeat (3) @(negedge clk);
        check("R10 out_valid", {63'b0, out_valid}, 64'h0);
        check("R10 result", result, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            convert(VEC[i][129], VEC[i][128], VEC[i][127:64]);
            check($sformatf("R%0d vec%0d valid", VEC[i][137:130], i), {63'b0, out_valid}, 64'h1);
            check($sformatf("R%0d vec%0d", VEC[i][137:130], i), result, VEC[i][63:0]);
        end

        // R9: idle cycle drops out_valid; back-to-back inputs each appear once
        @(negedge clk);
        check("R9 idle", {63'b0, out_valid}, 64'h0);
        @(negedge clk);
        in_valid = 1'b1; src_dbl = 1'b0; dst_long = 1'b0; src_bits = 64'h4040_0000; // 3.0
        @(negedge clk);
        check("R9 first", result, 64'h3);
        src_bits = 64'hC0E0_0000; // -7.0
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 second", result, 64'hFFFF_FFFF_FFFF_FFF9);
        check("R9 valid", {63'b0, out_valid}, 64'h1);
        @(negedge clk);
        check("R9 drop", {63'b0, out_valid}, 64'h0);

        // R10: reset mid-stream clears a nonzero result
        convert(1'b1, 1'b1, 64'h4006_0000_0000_0000);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid valid", {63'b0, out_valid}, 64'h0);
        check("R10 mid result", result, 64'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule